// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Cell

This block is one cell of a bit-serial SIMD array. Every cell in the array receives the same 22-bit command word and the same RAM address on each clock. Each cell has two one-bit-wide local memories and five one-bit state latches: NS, EW, C, CM and FLG. It also has a one-bit adder/subtractor. In a single cycle a cell reads one bit from each memory and updates any of its latches. It can write one result back to either memory at the shared address.

The cell exchanges bits with its four neighbours. The north and south outputs come from NS, and the east and west outputs come from EW. The CM register carries data along a separate communication path. A local condition flag, FLG, lets the cells of one array run different programs. While the flag is clear, the cell freezes its arithmetic state, but only if the command sets its condition-enable bit. The cell also drives an active-low term for an array-wide wired-OR output.

Top module: `pe_cell`

## Requirements
- R1: A synchronous active-high reset clears NS, EW, C and CM and sets FLG to 1. After reset every neighbour output and `cm_out` is 0, and `go_n` is 0 whenever bit 21 of the command is 0.
- R2: The command word layout is as follows. NS select is [2:0], EW select [5:3], C select [8:6], CM select [11:9] and FLG select [14:12]. The ALU operation is [16:15], write enable [17], write target [18] (0 = RAM A, 1 = RAM B), write-data select [20:19] and condition-enable C2 [21].
- R3: NS select codes: 0 = RAM A bit, 1 = RAM B bit, 2 = `north_in`, 3 = `south_in`, 4 = ALU sum, 5 = CM latch. `north_out` and `south_out` both carry NS.
- R4: EW select codes: 0 = RAM A bit, 1 = RAM B bit, 2 = `east_in`, 3 = `west_in`, 4 = ALU sum, 5 = ALU carry. `east_out` and `west_out` both carry EW.
- R5: C select codes: 0 = RAM A, 1 = RAM B, 2 = ALU carry, 3 = constant 0, 4 = constant 1, 5 = ALU sum. CM select codes: 0 = RAM A, 1 = RAM B, 2 = `cm_in`, 3 = NS latch, 4 = ALU sum, 5 = constant 0. `cm_out` carries CM.
- R6: FLG can be loaded either by a plain memory fetch or from an ALU result. FLG select codes: 0 = RAM A, 1 = RAM B, 2 = ALU carry, 3 = ALU sum, 4 = constant 1, 5 = constant 0.
- R7: The ALU takes A = NS, B = EW and CIN = C. Operation code 0 and code 3 compute A+B+CIN. Code 1 computes A-B-CIN and code 2 computes B-A-CIN. The sum bit is the low bit of the result. The carry output is the carry of an addition, or 1 when a subtraction result is negative (borrow).
- R8: The memory read is a read-modify-write in one cycle. Latch loads see the memory contents from before the clock edge, and the selected write goes in at that edge at the same address. Write-data select codes: 0 = ALU sum, 1 = ALU carry, 2 = CM latch, 3 = NS latch.
- R9: A select code of 6 or 7 loads nothing, so the latch it feeds keeps its value.
- R10: The condition signal is FG = (NOT C2) OR FLG. While FG is 0, NS, EW, C and FLG keep their values and no memory write happens.
- R11: CM loads according to its select code whatever the value of FG.
- R12: `go_n` is 0 exactly when FG is 1 and C is 0, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 22 | Global command word |
| addr | input | 6 | Shared bit address for both memories |
| north_in | input | 1 | Bit from the north neighbour |
| south_in | input | 1 | Bit from the south neighbour |
| east_in | input | 1 | Bit from the east neighbour |
| west_in | input | 1 | Bit from the west neighbour |
| cm_in | input | 1 | Communication-path input bit |
| north_out | output | 1 | NS latch to the north neighbour |
| south_out | output | 1 | NS latch to the south neighbour |
| east_out | output | 1 | EW latch to the east neighbour |
| west_out | output | 1 | EW latch to the west neighbour |
| cm_out | output | 1 | CM latch on the communication path |
| go_n | output | 1 | Active-low term for the wired-OR global output |

## Verification
The hardest state to reach is a frozen cell: C2 set and FLG cleared, while the command still tries to load every latch and write memory. The stimulus clears FLG with C2 at 0. It then issues commands that try every load and a write while masked, and checks that only CM moves. Next it lifts the mask through C2 and reads the targeted address back through NS, to show that the write never took place. Same-address read-modify-write and every ALU operation over all eight input combinations are also driven directly. These directed parts are followed by long random command streams, compared cycle by cycle against a behavioural model.

// File: rtl/pe_pkg.sv
package pe_pkg;

   localparam int SEL_W  = 3;
   localparam int N_SRC  = 6;
   localparam int OP_W   = 2;
   localparam int WSEL_W = 2;
   localparam int CMD_W  = 5 * SEL_W + OP_W + 2 + WSEL_W + 1;

   localparam int L_NS  = 0;
   localparam int L_EW  = 1;
   localparam int L_C   = 2;
   localparam int L_CM  = 3;
   localparam int L_FLG = 4;
   localparam int N_LAT = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 2'd0,
      OP_AMB  = 2'd1,
      OP_BMA  = 2'd2,
      OP_ADD2 = 2'd3
   } alu_op_e;

   typedef enum logic [WSEL_W-1:0] {
      WS_SUM   = 2'd0,
      WS_CARRY = 2'd1,
      WS_CM    = 2'd2,
      WS_NS    = 2'd3
   } wsel_e;

   typedef struct packed {
      logic             c2;
      wsel_e            wr_sel;
      logic             wr_dst;
      logic             wr_en;
      alu_op_e          op;
      logic [SEL_W-1:0] sel_flg;
      logic [SEL_W-1:0] sel_cm;
      logic [SEL_W-1:0] sel_c;
      logic [SEL_W-1:0] sel_ew;
      logic [SEL_W-1:0] sel_ns;
   } cmd_t;

endpackage

// File: rtl/pe_bitram.sv
module pe_bitram #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              wdata,
   output logic              rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("pe_bitram: ADDR_W out of supported range");
   end

   logic mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/pe_srcmux.sv
module pe_srcmux #(
   parameter int N_SRC = 6,
   parameter int SEL_W = 3
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             dout,
   output logic             hit
);
   if (N_SRC < 1 || N_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("pe_srcmux: N_SRC does not fit the select width");
   end

   always_comb begin
      dout = 1'b0;
      hit  = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) begin
            dout = src[i];
            hit  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
   import pe_pkg::*;
#(
   parameter bit INV_ADDER = 1'b1
) (
   input  logic    a,
   input  logic    b,
   input  logic    cin,
   input  alu_op_e op,
   output logic    sm,
   output logic    cy
);
   if (INV_ADDER) begin : g_inv
      logic sub, xa, xb, xc, maj;
      always_comb begin
         sub = (op == OP_AMB) || (op == OP_BMA);
         xa  = a ^ (op == OP_BMA);
         xb  = b ^ (op == OP_AMB);
         xc  = cin ^ sub;
         maj = (xa & xb) | (xa & xc) | (xb & xc);
         sm  = xa ^ xb ^ xc;
         cy  = maj ^ sub;
      end
   end else begin : g_direct
      always_comb begin
         sm = a ^ b ^ cin;
         unique case (op)
            OP_AMB:  cy = (~a & b) | (~a & cin) | (b & cin);
            OP_BMA:  cy = (~b & a) | (~b & cin) | (a & cin);
            default: cy = (a & b) | (a & cin) | (b & cin);
         endcase
      end
   end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
   import pe_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter bit INV_ADDER = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CMD_W-1:0]    cmd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                north_in,
   input  logic                south_in,
   input  logic                east_in,
   input  logic                west_in,
   input  logic                cm_in,
   output logic                north_out,
   output logic                south_out,
   output logic                east_out,
   output logic                west_out,
   output logic                cm_out,
   output logic                go_n
);
   if (CMD_W != $bits(cmd_t)) begin : g_bad_cmd
      $error("pe_cell: command width mismatch");
   end

   cmd_t             c;
   logic [N_LAT-1:0] lat_q;
   logic             rd_a, rd_b;
   logic             sm, cy;
   logic             fg;
   logic             wdata;
   logic             we_a, we_b;
   logic             flg_q, c_q;
   logic [N_SRC-1:0] src [N_LAT];
   logic [SEL_W-1:0] sel [N_LAT];

   assign c     = cmd_t'(cmd);
   assign flg_q = lat_q[L_FLG];
   assign c_q   = lat_q[L_C];
   assign fg    = ~c.c2 | flg_q;

   pe_alu #(.INV_ADDER(INV_ADDER)) u_alu (
      .a   (lat_q[L_NS]),
      .b   (lat_q[L_EW]),
      .cin (lat_q[L_C]),
      .op  (c.op),
      .sm  (sm),
      .cy  (cy)
   );

   always_comb begin
      src[L_NS]  = {lat_q[L_CM], sm, south_in, north_in, rd_b, rd_a};
      src[L_EW]  = {cy, sm, west_in, east_in, rd_b, rd_a};
      src[L_C]   = {sm, 1'b1, 1'b0, cy, rd_b, rd_a};
      src[L_CM]  = {1'b0, sm, lat_q[L_NS], cm_in, rd_b, rd_a};
      src[L_FLG] = {1'b0, 1'b1, sm, cy, rd_b, rd_a};
      sel[L_NS]  = c.sel_ns;
      sel[L_EW]  = c.sel_ew;
      sel[L_C]   = c.sel_c;
      sel[L_CM]  = c.sel_cm;
      sel[L_FLG] = c.sel_flg;
   end

   for (genvar i = 0; i < N_LAT; i++) begin : g_lat
      localparam logic RST_VAL = (i == L_FLG);
      localparam bit   MASKED  = (i != L_CM);
      logic d, hit, q;

      pe_srcmux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
         .src  (src[i]),
         .sel  (sel[i]),
         .dout (d),
         .hit  (hit)
      );

      always_ff @(posedge clk) begin
         if (rst)                      q <= RST_VAL;
         else if (hit && (!MASKED || fg)) q <= d;
      end

      assign lat_q[i] = q;
   end

   always_comb begin
      unique case (c.wr_sel)
         WS_SUM:   wdata = sm;
         WS_CARRY: wdata = cy;
         WS_CM:    wdata = lat_q[L_CM];
         default:  wdata = lat_q[L_NS];
      endcase
   end

   assign we_a = c.wr_en & fg & ~c.wr_dst & ~rst;
   assign we_b = c.wr_en & fg &  c.wr_dst & ~rst;

   pe_bitram #(.ADDR_W(ADDR_W)) u_ram_a (
      .clk (clk), .addr (addr), .we (we_a), .wdata (wdata), .rdata (rd_a)
   );

   pe_bitram #(.ADDR_W(ADDR_W)) u_ram_b (
      .clk (clk), .addr (addr), .we (we_b), .wdata (wdata), .rdata (rd_b)
   );

   assign north_out = lat_q[L_NS];
   assign south_out = lat_q[L_NS];
   assign east_out  = lat_q[L_EW];
   assign west_out  = lat_q[L_EW];
   assign cm_out    = lat_q[L_CM];
   assign go_n      = ~(fg & ~c_q);
endmodule

// File: rtl/pe_cell_chk.sv
module pe_cell_chk
   import pe_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic [CMD_W-1:0] cmd,
   input logic             cm_in,
   input logic             north_out,
   input logic             east_out,
   input logic             cm_out,
   input logic             go_n,
   input logic             flg_q,
   input logic             c_q
);
   cmd_t k;
   assign k = cmd_t'(cmd);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!north_out && !east_out && !cm_out && !c_q && flg_q));

   assert_hold_code_ns_R9: assert property (@(posedge clk) disable iff (rst)
      (k.sel_ns >= 3'd6) |=> $stable(north_out));

   assert_hold_code_ew_R9: assert property (@(posedge clk) disable iff (rst)
      (k.sel_ew >= 3'd6) |=> $stable(east_out));

   assert_mask_freeze_R10: assert property (@(posedge clk) disable iff (rst)
      (k.c2 && !flg_q) |=> ($stable(north_out) && $stable(east_out)
                            && $stable(c_q) && $stable(flg_q)));

   assert_cm_unmasked_R11: assert property (@(posedge clk) disable iff (rst)
      (k.c2 && !flg_q && k.sel_cm == 3'd2) |=> (cm_out == $past(cm_in)));

   assert_go_pull_R12: assert property (@(posedge clk) disable iff (rst)
      (!k.c2 && !c_q) |-> !go_n);

   assert_go_release_R12: assert property (@(posedge clk) disable iff (rst)
      c_q |-> go_n);
endmodule

bind pe_cell pe_cell_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd       (cmd),
   .cm_in     (cm_in),
   .north_out (north_out),
   .east_out  (east_out),
   .cm_out    (cm_out),
   .go_n      (go_n),
   .flg_q     (flg_q),
   .c_q       (c_q)
);

// File: tb/pe_cell_tb_top.sv
module pe_cell_tb_top;
   import pe_pkg::*;

   localparam int AW = 6;
   localparam int NW = 1 << AW;
   localparam logic [2:0] H = 3'd7;

   logic clk = 1'b0;
   logic rst;
   logic [CMD_W-1:0] cmd;
   logic [AW-1:0] addr;
   logic north_in, south_in, east_in, west_in, cm_in;
   logic north_out, south_out, east_out, west_out, cm_out, go_n;

   int total = 0;
   int bad   = 0;

   int m_ns, m_ew, m_c, m_cm, m_flg;
   int m_a [NW];
   int m_b [NW];

   always #10 clk = ~clk;

   pe_cell #(.ADDR_W(AW)) dut_i (
      .clk (clk), .rst (rst), .cmd (cmd), .addr (addr),
      .north_in (north_in), .south_in (south_in), .east_in (east_in),
      .west_in (west_in), .cm_in (cm_in),
      .north_out (north_out), .south_out (south_out), .east_out (east_out),
      .west_out (west_out), .cm_out (cm_out), .go_n (go_n)
   );

   function automatic logic [CMD_W-1:0] mk(
      input int sns, input int sew, input int sc, input int scm, input int sfl,
      input int op, input int we, input int dst, input int ws, input int c2);
      logic [CMD_W-1:0] v;
      v = '0;
      v[2:0]   = 3'(sns);
      v[5:3]   = 3'(sew);
      v[8:6]   = 3'(sc);
      v[11:9]  = 3'(scm);
      v[14:12] = 3'(sfl);
      v[16:15] = 2'(op);
      v[17]    = 1'(we);
      v[18]    = 1'(dst);
      v[20:19] = 2'(ws);
      v[21]    = 1'(c2);
      return v;
   endfunction

   function automatic logic [5:0] expect_vec(input int c2);
      int fgv;
      fgv = (c2 == 0 || m_flg == 1) ? 1 : 0;
      return {1'(m_ns), 1'(m_ns), 1'(m_ew), 1'(m_ew), 1'(m_cm),
              1'((fgv == 1 && m_c == 0) ? 0 : 1)};
   endfunction

   task automatic check(input string tag, input int c2);
      logic [5:0] got, exp;
      got = {north_out, south_out, east_out, west_out, cm_out, go_n};
      exp = expect_vec(c2);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: outputs {n,s,e,w,cm,go_n} actual=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic step(input logic [CMD_W-1:0] cw, input int ad,
                       input int ni, input int si, input int ei, input int wi,
                       input int ci, input string tag);
      int ra, rb, res, sm, cy, fgv, nns, new_ew, nc, ncm, nfl, wd, op;
      cmd = cw; addr = AW'(ad);
      north_in = 1'(ni); south_in = 1'(si); east_in = 1'(ei);
      west_in = 1'(wi); cm_in = 1'(ci);
      ra = m_a[ad]; rb = m_b[ad];
      op = int'(cw[16:15]);
      if (op == 1)      res = m_ns - m_ew - m_c;
      else if (op == 2) res = m_ew - m_ns - m_c;
      else              res = m_ns + m_ew + m_c;
      sm = res & 1;
      cy = (op == 1 || op == 2) ? (res < 0 ? 1 : 0) : (res >> 1);
      fgv = (cw[21] == 1'b0 || m_flg == 1) ? 1 : 0;
      nns = m_ns; new_ew = m_ew; nc = m_c; ncm = m_cm; nfl = m_flg;
      case (int'(cw[2:0]))
         0: nns = ra; 1: nns = rb; 2: nns = ni; 3: nns = si; 4: nns = sm; 5: nns = m_cm;
         default: ;
      endcase
      case (int'(cw[5:3]))
         0: new_ew = ra; 1: new_ew = rb; 2: new_ew = ei; 3: new_ew = wi; 4: new_ew = sm; 5: new_ew = cy;
         default: ;
      endcase
      case (int'(cw[8:6]))
         0: nc = ra; 1: nc = rb; 2: nc = cy; 3: nc = 0; 4: nc = 1; 5: nc = sm;
         default: ;
      endcase
      case (int'(cw[11:9]))
         0: ncm = ra; 1: ncm = rb; 2: ncm = ci; 3: ncm = m_ns; 4: ncm = sm; 5: ncm = 0;
         default: ;
      endcase
      case (int'(cw[14:12]))
         0: nfl = ra; 1: nfl = rb; 2: nfl = cy; 3: nfl = sm; 4: nfl = 1; 5: nfl = 0;
         default: ;
      endcase
      case (int'(cw[20:19]))
         0: wd = sm; 1: wd = cy; 2: wd = m_cm; default: wd = m_ns;
      endcase
      if (cw[17] && fgv == 1) begin
         if (cw[18]) m_b[ad] = wd; else m_a[ad] = wd;
      end
      m_cm = ncm;
      if (fgv == 1) begin
         m_ns = nns; m_ew = new_ew; m_c = nc; m_flg = nfl;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(cw[21]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      cmd = mk(H, H, H, H, H, 0, 0, 0, 0, 0);
      addr = '0;
      north_in = 0; south_in = 0; east_in = 0; west_in = 0; cm_in = 0;
      m_ns = 0; m_ew = 0; m_c = 0; m_cm = 0; m_flg = 1;
      for (int i = 0; i < NW; i++) begin m_a[i] = 0; m_b[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset state", 0);

      // R8: fill both memories through NS and CM write paths
      for (int i = 0; i < NW; i++) begin
         step(mk(2, H, H, 2, H, 0, 0, 0, 0, 0), i, (i * 7 + 1) % 3 == 0 ? 1 : 0, 0, 0, 0,
              (i % 5) < 2 ? 1 : 0, "R3 R5 load");
         step(mk(H, H, H, H, H, 0, 1, 0, 3, 0), i, 0, 0, 0, 0, 0, "R8 write ns to A");
         step(mk(H, H, H, H, H, 0, 1, 1, 2, 0), i, 0, 0, 0, 0, 0, "R8 write cm to B");
      end

      // R3 R4: fetch memories into NS and EW, neighbour paths
      for (int i = 0; i < 8; i++) begin
         step(mk(0, 1, H, H, H, 0, 0, 0, 0, 0), i * 5, 0, 0, 0, 0, 0, "R3 R4 fetch");
         step(mk(3, 3, H, H, H, 0, 0, 0, 0, 0), 0, 0, i & 1, 0, (i >> 1) & 1, 0, "R3 R4 south/west");
         step(mk(5, 2, H, H, H, 0, 0, 0, 0, 0), 0, 0, 0, i & 1, 0, 0, "R3 R4 cm/east");
      end

      // R7: every operation and input combination
      for (int op = 0; op < 4; op++) begin
         for (int v = 0; v < 8; v++) begin
            step(mk(2, 2, (v & 4) != 0 ? 4 : 3, H, H, 0, 0, 0, 0, 0), 0,
                 v & 1, 0, (v >> 1) & 1, 0, 0, "R7 operands");
            step(mk(H, 4, 2, H, H, op, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, "R7 sum and carry");
         end
      end

      // R5 R6: C and FLG sources, FLG from memory fetch and from ALU
      step(mk(2, 2, 4, 3, 2, 0, 0, 0, 0, 0), 1, 1, 0, 1, 0, 0, "R5 R6 flg from carry");
      step(mk(H, H, 5, 4, 3, 0, 0, 0, 0, 0), 1, 0, 0, 0, 0, 0, "R5 R6 flg from sum");
      for (int i = 0; i < 6; i++)
         step(mk(H, H, i % 2, 1 - (i % 2), i % 2, 0, 0, 0, 0, 0), i, 0, 0, 0, 0, 0, "R6 flg fetch");
      step(mk(H, H, 3, 5, 4, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, "R5 R6 constants");

      // R8: read-modify-write at one address, old value seen by latch
      step(mk(2, H, H, H, H, 0, 0, 0, 0, 0), 9, m_a[9] == 0 ? 1 : 0, 0, 0, 0, 0, "R8 prep");
      step(mk(0, H, H, H, H, 0, 1, 0, 3, 0), 9, 0, 0, 0, 0, 0, "R8 old value read");
      step(mk(0, H, H, H, H, 0, 0, 0, 0, 0), 9, 0, 0, 0, 0, 0, "R8 new value read");
      step(mk(2, 2, 4, H, H, 0, 0, 0, 0, 0), 10, 1, 0, 1, 0, 0, "R8 prep sum");
      step(mk(H, H, H, H, H, 0, 1, 1, 1, 0), 10, 0, 0, 0, 0, 0, "R8 write carry to B");
      step(mk(H, 1, H, H, H, 0, 0, 0, 0, 0), 10, 0, 0, 0, 0, 0, "R8 carry readback");

      // R9: unused codes hold every latch
      step(mk(2, 2, 4, 2, 5, 0, 0, 0, 0, 0), 0, 1, 0, 1, 0, 1, "R9 prep");
      step(mk(6, 7, 6, 7, 6, 0, 0, 0, 0, 0), 0, 0, 1, 0, 1, 0, "R9 hold codes");
      step(mk(7, 6, 7, 6, 7, 1, 0, 0, 0, 0), 3, 0, 0, 0, 0, 0, "R9 hold codes");

      // R10 R11 R12: freeze by flag, override by C2
      step(mk(2, 2, 3, H, 5, 0, 0, 0, 0, 0), 20, 1, 0, 1, 0, 0, "R10 clear flag");
      step(mk(3, 3, 4, 2, 4, 0, 1, 0, 0, 1), 20, 0, 0, 0, 0, 1, "R10 R11 R12 masked");
      step(mk(2, 2, 4, 2, 4, 0, 1, 1, 3, 1), 20, 0, 0, 0, 0, 0, "R10 R11 R12 masked");
      step(mk(0, 1, H, H, H, 0, 0, 0, 0, 0), 20, 0, 0, 0, 0, 0, "R10 no write while masked");
      step(mk(H, H, 4, H, H, 0, 0, 0, 0, 0), 20, 0, 0, 0, 0, 0, "R10 override by C2");
      step(mk(H, H, H, H, 4, 0, 0, 0, 0, 0), 20, 0, 0, 0, 0, 0, "R10 R12 unmask");
      step(mk(H, H, 3, H, H, 0, 0, 0, 0, 1), 20, 0, 0, 0, 0, 0, "R12 go pull");

      // R2: random command stream against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(CMD_W'($urandom), int'($urandom % NW), int'(r[0]), int'(r[1]),
              int'(r[2]), int'(r[3]), int'(r[4]), "R2 random command");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule